// File: doc/BRIEF.md
# Two-Entry Translation Fast-Path Cache

This block sits in front of a full address-translation unit and answers the easy requests without a full search. It keeps two recently completed translations, plus a copy of the 64-bit translation-control word that was in force when they were loaded. A lookup request supplies a virtual address, an access size in bytes, an address-space identifier, a write flag, the current control word, and hyperprivileged and implicit-access flags. One cycle after the request strobe the block reports either a hit, with a physical address and an uncacheable flag, or a miss. On a miss the full translation unit handles the request.

Once the full unit has finished a translation, it loads that result into one of the two slots through the fill port and supplies the control word that the translation used. A single-cycle invalidate input drops the whole cache, for example after a demap or a mode switch. The control word has these fields: bit 1 is a red-state flag, bit 2 is privileged mode, bit 3 is address masking, bit 5 enables the data MMU, bits 15:8 hold the partition, bits 18:16 hold the trap level and bits 47:32 hold the primary context. The cache does not decode these fields. It compares the whole word, so a change in any field forces a miss.

Top module: `xlat_fastpath_cache`

## Requirements
- R1: When a request has both req_hpriv and req_implicit set, the block does no lookup. It responds with a hit, rsp_pa equal to the low 40 bits of req_va, and rsp_uncache low, whatever the cache holds.
- R2: While the cache holds no valid contents (after reset or after an invalidate, and before the next fill), every request that is not a bypass gets a miss.
- R3: A non-bypass request whose req_ctl differs in any bit from the control word stored by the most recent fill gets a miss, even if an entry would otherwise match.
- R4: An entry can hit only when its stored address-space identifier equals req_asi.
- R5: An entry covers the bytes [base, base + mask + 1). It matches when this range overlaps the accessed bytes [req_va, req_va + req_size). An access that only straddles the entry's start or end still matches. An access that ends exactly at the base, or starts exactly at the end of the range, does not match.
- R6: A write request (req_write = 1) can hit only an entry whose writable bit is set. Read requests ignore the writable bit.
- R7: When both entries match, entry 0 supplies the result.
- R8: On a hit, rsp_pa is the entry's frame address ORed with the low 40 bits of req_va ANDed with the entry's offset mask.
- R9: On a hit, rsp_uncache is 1 exactly when the hitting entry has its side-effect bit set or its frame address has bit 39 set. On a miss, rsp_uncache is 0.
- R10: A fill writes the slot named by fill_slot and stores fill_ctl as the cache key. If the cache was invalid before the fill, the other slot is cleared in the same cycle. If the cache was already valid, the other slot keeps its contents.
- R11: An invalidate makes the cache invalid at the next clock edge. If fill_valid is asserted in the same cycle as the invalidate, the fill is ignored.
- R12: rsp_valid, rsp_hit, rsp_miss, rsp_pa and rsp_uncache are registered. They reflect the request presented in the previous cycle. In a cycle after one with no request, rsp_valid, rsp_hit and rsp_miss are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | 64 | Virtual address of the access |
| req_size | input | 5 | Access size in bytes |
| req_asi | input | 8 | Address-space identifier of the access |
| req_write | input | 1 | Access is a store |
| req_ctl | input | 64 | Current translation-control word |
| req_hpriv | input | 1 | Hyperprivileged request |
| req_implicit | input | 1 | Implicit address space |
| fill_valid | input | 1 | Load one slot |
| fill_slot | input | 1 | Slot to load |
| fill_ctl | input | 64 | Control word the translation was made under |
| fill_va | input | 64 | Base virtual address of the page |
| fill_mask | input | 64 | Page-offset mask (page size minus one) |
| fill_frame | input | 40 | Page-frame physical address |
| fill_asi | input | 8 | Address-space identifier of the entry |
| fill_writable | input | 1 | Page permits writes |
| fill_side_eff | input | 1 | Page has side effects |
| inval | input | 1 | Drop all cached contents |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation answered here |
| rsp_miss | output | 1 | Request must go to the full translation unit |
| rsp_pa | output | 40 | Physical address (valid on hit) |
| rsp_uncache | output | 1 | Access must bypass the caches |

## Verification
The hardest case to reach is a request that both slots match, where entry 0 must still be dropped because it fails the write check. This needs two fills of overlapping pages with different permissions while the cache stays valid, followed by a matching store. The bench builds this case by loading a read-only small page into slot 0 and a writable large page that covers it into slot 1. It then issues a read and a write to the same address. The read must return the slot 0 frame, and the write must return the slot 1 frame with bit 39 set. The cold-fill clearing rule needs a similar setup: the bench invalidates a populated cache, refills only slot 1 under a new control word, and confirms that the old slot 0 contents no longer hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 64;
    localparam int PA_W   = 40;
    localparam int ASI_W  = 8;
    localparam int CTL_W  = 64;
    localparam int SZ_W   = 5;
    localparam int N_ENT  = 2;
    localparam int SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int NC_BIT = 39;

    localparam logic [VA_W:0] ONE_X = (VA_W+1)'(1);

    typedef struct packed {
        logic             valid;
        logic [ASI_W-1:0] asi;
        logic [VA_W-1:0]  base;
        logic [VA_W-1:0]  off_mask;
        logic [PA_W-1:0]  frame;
        logic             writable;
        logic             side_eff;
    } xl_entry_t;

    typedef struct packed {
        logic [VA_W-1:0]  va;
        logic [SZ_W-1:0]  size;
        logic [ASI_W-1:0] asi;
        logic             write;
        logic [CTL_W-1:0] ctl;
        logic             hpriv;
        logic             implicit;
    } xl_req_t;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_MISS,
        RSP_HIT,
        RSP_BYPASS
    } xl_kind_e;

    function automatic logic [PA_W-1:0] impl_pa(input logic [VA_W-1:0] va);
        return va[PA_W-1:0];
    endfunction

    function automatic logic range_overlap(input logic [VA_W-1:0] base,
                                           input logic [VA_W-1:0] mask,
                                           input logic [VA_W-1:0] va,
                                           input logic [SZ_W-1:0] sz);
        logic [VA_W:0] acc_end;
        logic [VA_W:0] ent_end;
        acc_end = {1'b0, va} + (VA_W+1)'(sz);
        ent_end = {1'b0, base} + {1'b0, mask} + ONE_X;
        return ({1'b0, base} < acc_end) && (ent_end > {1'b0, va});
    endfunction

    function automatic logic [PA_W-1:0] form_pa(input xl_entry_t e,
                                                input logic [VA_W-1:0] va);
        return e.frame | (va[PA_W-1:0] & e.off_mask[PA_W-1:0]);
    endfunction

    function automatic logic no_cache(input xl_entry_t e);
        return e.side_eff | e.frame[NC_BIT];
    endfunction

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
    import xlat_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inval,
    input  logic                        fill_valid,
    input  logic [SLOT_W-1:0]           fill_slot,
    input  logic [CTL_W-1:0]            fill_ctl,
    input  xl_entry_t                   fill_entry,
    output xl_entry_t [N_ENT-1:0]       ent_q,
    output logic [CTL_W-1:0]            key_q,
    output logic                        cache_vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_vld_q <= 1'b0;
            key_q       <= '0;
            for (int i = 0; i < N_ENT; i++) begin
                ent_q[i] <= '0;
            end
        end else if (inval) begin
            cache_vld_q <= 1'b0;
        end else if (fill_valid) begin
            key_q       <= fill_ctl;
            cache_vld_q <= 1'b1;
            for (int i = 0; i < N_ENT; i++) begin
                if (!cache_vld_q) begin
                    ent_q[i].valid <= 1'b0;
                end
            end
            ent_q[fill_slot]       <= fill_entry;
            ent_q[fill_slot].valid <= 1'b1;
        end
    end

endmodule

// File: rtl/xlat_entry_match.sv
module xlat_entry_match
    import xlat_pkg::*;
(
    input  xl_entry_t [N_ENT-1:0] ent,
    input  xl_req_t               req,
    output logic [N_ENT-1:0]      hit_vec
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic asi_eq;
        logic span_ok;
        logic perm_ok;
        assign asi_eq  = (ent[g].asi == req.asi);
        assign span_ok = range_overlap(ent[g].base, ent[g].off_mask, req.va, req.size);
        assign perm_ok = !req.write || ent[g].writable;
        assign hit_vec[g] = ent[g].valid && asi_eq && span_ok && perm_ok;
    end

endmodule

// File: rtl/xlat_result_sel.sv
module xlat_result_sel
    import xlat_pkg::*;
(
    input  xl_entry_t [N_ENT-1:0] ent,
    input  logic [N_ENT-1:0]      hit_vec,
    input  logic [VA_W-1:0]       va,
    output logic                  any_hit,
    output logic [PA_W-1:0]       pa,
    output logic                  uncache
);

    xl_entry_t pick;

    // lowest index wins: scan downward so slot 0 is assigned last
    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                pick    = ent[i];
            end
        end
    end

    assign pa      = form_pa(pick, va);
    assign uncache = any_hit && no_cache(pick);

endmodule

// File: rtl/xlat_fastpath_cache.sv
module xlat_fastpath_cache
    import xlat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_va,
    input  logic [SZ_W-1:0]       req_size,
    input  logic [ASI_W-1:0]      req_asi,
    input  logic                  req_write,
    input  logic [CTL_W-1:0]      req_ctl,
    input  logic                  req_hpriv,
    input  logic                  req_implicit,
    input  logic                  fill_valid,
    input  logic [SLOT_W-1:0]     fill_slot,
    input  logic [CTL_W-1:0]      fill_ctl,
    input  logic [VA_W-1:0]       fill_va,
    input  logic [VA_W-1:0]       fill_mask,
    input  logic [PA_W-1:0]       fill_frame,
    input  logic [ASI_W-1:0]      fill_asi,
    input  logic                  fill_writable,
    input  logic                  fill_side_eff,
    input  logic                  inval,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic [PA_W-1:0]       rsp_pa,
    output logic                  rsp_uncache
);

    xl_req_t               req;
    xl_entry_t             fill_entry;
    xl_entry_t [N_ENT-1:0] ent_q;
    logic [CTL_W-1:0]      key_q;
    logic                  cache_vld;
    logic [N_ENT-1:0]      hit_vec;
    logic                  any_hit;
    logic [PA_W-1:0]       sel_pa;
    logic                  sel_unc;
    logic                  key_ok;
    xl_kind_e              kind;

    assign req = '{va: req_va, size: req_size, asi: req_asi, write: req_write,
                   ctl: req_ctl, hpriv: req_hpriv, implicit: req_implicit};

    assign fill_entry = '{valid: 1'b1, asi: fill_asi, base: fill_va,
                          off_mask: fill_mask, frame: fill_frame,
                          writable: fill_writable, side_eff: fill_side_eff};

    xlat_entry_store u_store (
        .clk         (clk),
        .rst         (rst),
        .inval       (inval),
        .fill_valid  (fill_valid),
        .fill_slot   (fill_slot),
        .fill_ctl    (fill_ctl),
        .fill_entry  (fill_entry),
        .ent_q       (ent_q),
        .key_q       (key_q),
        .cache_vld_q (cache_vld)
    );

    xlat_entry_match u_match (
        .ent     (ent_q),
        .req     (req),
        .hit_vec (hit_vec)
    );

    xlat_result_sel u_sel (
        .ent     (ent_q),
        .hit_vec (hit_vec),
        .va      (req_va),
        .any_hit (any_hit),
        .pa      (sel_pa),
        .uncache (sel_unc)
    );

    assign key_ok = cache_vld && (key_q == req.ctl);

    always_comb begin
        if (!req_valid)                       kind = RSP_NONE;
        else if (req.hpriv && req.implicit)   kind = RSP_BYPASS;
        else if (key_ok && any_hit)           kind = RSP_HIT;
        else                                  kind = RSP_MISS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_pa      <= '0;
            rsp_uncache <= 1'b0;
        end else begin
            rsp_valid   <= (kind != RSP_NONE);
            rsp_hit     <= (kind == RSP_HIT) || (kind == RSP_BYPASS);
            rsp_miss    <= (kind == RSP_MISS);
            rsp_uncache <= (kind == RSP_HIT) && sel_unc;
            case (kind)
                RSP_BYPASS: rsp_pa <= impl_pa(req.va);
                RSP_HIT:    rsp_pa <= sel_pa;
                default:    rsp_pa <= '0;
            endcase
        end
    end

endmodule

// File: rtl/xlat_fastpath_chk.sv
module xlat_fastpath_chk
    import xlat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [PA_W-1:0]  req_va_lo,
    input logic [CTL_W-1:0] req_ctl,
    input logic             req_hpriv,
    input logic             req_implicit,
    input logic             inval,
    input logic [CTL_W-1:0] key_q,
    input logic             cache_vld,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_uncache
);

    AST_BYPASS_PA: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_hpriv && req_implicit |=>
            rsp_hit && !rsp_uncache && (rsp_pa == $past(req_va_lo))); // R1

    AST_COLD_MISS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !(req_hpriv && req_implicit) && !cache_vld |=> rsp_miss); // R2

    AST_KEY_MISS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !(req_hpriv && req_implicit) && (key_q != req_ctl) |=> rsp_miss); // R3

    AST_UNC_ONLY_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_uncache |-> rsp_hit); // R9

    AST_INVAL_DROPS: assert property (@(posedge clk) disable iff (rst)
        inval |=> !cache_vld); // R11

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid && (rsp_hit != rsp_miss)); // R12

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss); // R12

endmodule

bind xlat_fastpath_cache xlat_fastpath_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_va_lo    (req_va[xlat_pkg::PA_W-1:0]),
    .req_ctl      (req_ctl),
    .req_hpriv    (req_hpriv),
    .req_implicit (req_implicit),
    .inval        (inval),
    .key_q        (key_q),
    .cache_vld    (cache_vld),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_pa       (rsp_pa),
    .rsp_uncache  (rsp_uncache)
);

// File: tb/xlat_fastpath_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_fastpath_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [4:0]  req_size = '0;
    logic [7:0]  req_asi = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_ctl = '0;
    logic        req_hpriv = 1'b0;
    logic        req_implicit = 1'b0;
    logic        fill_valid = 1'b0;
    logic [0:0]  fill_slot = '0;
    logic [63:0] fill_ctl = '0;
    logic [63:0] fill_va = '0;
    logic [63:0] fill_mask = '0;
    logic [39:0] fill_frame = '0;
    logic [7:0]  fill_asi = '0;
    logic        fill_writable = 1'b0;
    logic        fill_side_eff = 1'b0;
    logic        inval = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_uncache;
    logic [39:0] rsp_pa;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0] C1 = 64'h0000_5A5A_0003_0526;
    localparam logic [63:0] C2 = C1 ^ (64'h1 << 40);
    localparam logic [63:0] A  = 64'h0000_0000_4000_0000;
    localparam logic [63:0] B  = 64'h0000_0000_7000_0000;

    always #2.5 clk = ~clk;

    xlat_fastpath_cache dut_i (.*);

    task automatic expect_rsp(input string tag, input logic eh,
                              input logic [39:0] epa, input logic eu);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh ||
            (eh && rsp_pa !== epa) || rsp_uncache !== eu) begin
            n_bad++;
            $display("FAIL %s: got v=%b hit=%b miss=%b pa=%h unc=%b, expected hit=%b pa=%h unc=%b",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_pa, rsp_uncache, eh, epa, eu);
        end
    endtask

    task automatic lookup(input logic [63:0] va, input logic [4:0] sz,
                          input logic [7:0] asi, input logic wr,
                          input logic [63:0] ctl, input logic hp, input logic imp);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_size = sz; req_asi = asi;
        req_write = wr; req_ctl = ctl; req_hpriv = hp; req_implicit = imp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic slot, input logic [63:0] ctl,
                        input logic [63:0] va, input logic [63:0] mask,
                        input logic [39:0] frame, input logic [7:0] asi,
                        input logic wr, input logic se, input logic with_inval);
        @(negedge clk);
        fill_valid = 1'b1; fill_slot = slot; fill_ctl = ctl; fill_va = va;
        fill_mask = mask; fill_frame = frame; fill_asi = asi;
        fill_writable = wr; fill_side_eff = se; inval = with_inval;
        @(negedge clk);
        fill_valid = 1'b0; inval = 1'b0;
    endtask

    task automatic t_reset_state;
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset: got v=%b h=%b m=%b, expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_miss);
        end
        lookup(A, 5'd8, 8'h80, 1'b0, 64'h0, 1'b0, 1'b0);
        expect_rsp("R2 cold miss after reset", 1'b0, 40'h0, 1'b0);
    endtask

    task automatic t_bypass;
        lookup(64'hFFFF_FF12_3456_789A, 5'd4, 8'h14, 1'b1, 64'h0, 1'b1, 1'b1);
        expect_rsp("R1 bypass", 1'b1, 40'h12_3456_789A, 1'b0);
    endtask

    task automatic t_basic_hit;
        fill(1'b0, C1, A, 64'h1FFF, 40'h00_1234_6000, 8'h80, 1'b0, 1'b0, 1'b0);
        lookup(A + 64'h123, 5'd8, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R8 pa formation", 1'b1, 40'h00_1234_6123, 1'b0);
        lookup(A + 64'h123, 5'd8, 8'h81, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R4 asi mismatch", 1'b0, 40'h0, 1'b0);
        lookup(A + 64'h123, 5'd8, 8'h80, 1'b0, C2, 1'b0, 1'b0);
        expect_rsp("R3 control word change", 1'b0, 40'h0, 1'b0);
        lookup(A + 64'h123, 5'd8, 8'h80, 1'b1, C1, 1'b0, 1'b0);
        expect_rsp("R6 write to read-only", 1'b0, 40'h0, 1'b0);
        lookup(A + 64'h123, 5'd8, 8'h80, 1'b0, C1, 1'b1, 1'b1);
        expect_rsp("R1 bypass with live cache", 1'b1, 40'h00_4000_0123, 1'b0);
    endtask

    task automatic t_range_edges;
        lookup(A - 64'h4, 5'd8, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R5 straddle start", 1'b1, 40'h00_1234_7FFC, 1'b0);
        lookup(A - 64'h8, 5'd8, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R5 ends at base", 1'b0, 40'h0, 1'b0);
        lookup(A + 64'h1FFF, 5'd1, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R5 last byte", 1'b1, 40'h00_1234_7FFF, 1'b0);
        lookup(A + 64'h2000, 5'd1, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R5 past end", 1'b0, 40'h0, 1'b0);
    endtask

    task automatic t_two_slots;
        fill(1'b1, C1, A, 64'hFFFF, 40'h80_00A3_0000, 8'h80, 1'b1, 1'b0, 1'b0);
        lookup(A + 64'h10, 5'd8, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R7 slot0 priority / R13 slot0 kept", 1'b1, 40'h00_1234_6010, 1'b0);
        lookup(A + 64'h10, 5'd8, 8'h80, 1'b1, C1, 1'b0, 1'b0);
        expect_rsp("R6 write falls to slot1 / R9 bit39", 1'b1, 40'h80_00A3_0010, 1'b1);
        lookup(A + 64'h3000, 5'd4, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R9 slot1 only", 1'b1, 40'h80_00A3_3000, 1'b1);
        fill(1'b0, C1, B, 64'hFFF, 40'h00_0050_0000, 8'h81, 1'b0, 1'b1, 1'b0);
        lookup(B + 64'h4, 5'd4, 8'h81, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R9 side effect", 1'b1, 40'h00_0050_0004, 1'b1);
        lookup(A + 64'h3000, 5'd4, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R10 warm fill keeps other slot", 1'b1, 40'h80_00A3_3000, 1'b1);
    endtask

    task automatic t_invalidate_refill;
        @(negedge clk); inval = 1'b1;
        @(negedge clk); inval = 1'b0;
        lookup(B + 64'h4, 5'd4, 8'h81, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R11 invalidate / R2", 1'b0, 40'h0, 1'b0);
        fill(1'b1, C2, A, 64'hFFFF, 40'h00_0077_0000, 8'h80, 1'b1, 1'b0, 1'b0);
        lookup(B + 64'h4, 5'd4, 8'h81, 1'b0, C2, 1'b0, 1'b0);
        expect_rsp("R10 cold fill clears slot0", 1'b0, 40'h0, 1'b0);
        lookup(A + 64'h20, 5'd4, 8'h80, 1'b1, C2, 1'b0, 1'b0);
        expect_rsp("R10 new key and slot1", 1'b1, 40'h00_0077_0020, 1'b0);
        lookup(A + 64'h20, 5'd4, 8'h80, 1'b0, C1, 1'b0, 1'b0);
        expect_rsp("R3 old key misses", 1'b0, 40'h0, 1'b0);
        fill(1'b0, C2, B, 64'hFFF, 40'h00_0066_0000, 8'h82, 1'b1, 1'b0, 1'b1);
        lookup(B, 5'd4, 8'h82, 1'b0, C2, 1'b0, 1'b0);
        expect_rsp("R11 invalidate beats fill", 1'b0, 40'h0, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 idle: got v=%b h=%b m=%b, expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_miss);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R12 responses stalled)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_bypass();
        t_basic_hit();
        t_range_edges();
        t_two_slots();
        t_invalidate_refill();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule